// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time for a chip. A one-cycle tick enable, produced elsewhere once per second, advances a seconds/minutes/hours counter held in packed BCD. It also advances a binary day count (15 bits by default) that rolls forward at midnight. Software reaches the counter through a byte-wide register file with a single shared address bus. Reads are combinational. Writes take effect at the clock edge.

An alarm holds a minute, an hour and a day value, and each field has its own compare enable. The alarm is evaluated only at the instant the seconds roll over to zero. A match latches a sticky flag. The flag is cleared by writing a 1 to it, and it drives the interrupt output when the interrupt enable is set. A busy bit shows the cycle in which a tick updates the counters. A register write that lands in that cycle is parked in a one-entry holding slot and applied in the next non-busy cycle, so software never races the counter.

Top module: `rtc_calendar`

## Requirements
- R1: After reset every register, including control, time, day and alarm registers, reads 0x00 and `irqOut` is low.
- R2: Seconds (address 0x15) advance by one BCD step only in a cycle where `tickEn` is high and the run bit (control bit 0) is set. They roll from 0x59 to 0x00 and carry into minutes; the low digit rolls from 9 into the tens digit.
- R3: Minutes (0x16) roll from 0x59 to 0x00 on a seconds carry and carry into hours. Hours (0x17) count in BCD through 0x09 to 0x10.
- R4: Hours roll from 0x23 to 0x00 and increment the binary day count. Its low byte is at 0x18 and its upper bits are at 0x19 bits 6:0, with bit 7 reading 0. The count carries across the byte boundary and wraps from 0x7FFF to 0.
- R5: The alarm minute (0x1A), alarm hour (0x1B), alarm day low (0x1C) and alarm day high (0x1D, bits 6:0) read back what was written. An unmapped address reads 0x00.
- R6: Control register 0x14 fields: bit 7 busy (read-only), bit 6 reads 0, bit 5 day-compare enable, bit 4 hour-compare enable, bit 3 minute-compare enable, bit 2 alarm flag, bit 1 interrupt enable, bit 0 run.
- R7: Busy reads 1 in a cycle where a tick advances the counter. A write presented in such a cycle is not applied at that edge; it is applied at the end of the next non-busy cycle.
- R8: The alarm flag sets only on a tick that rolls seconds to 0x00 and leaves at least one compare enable set with every enabled field equal to the new minute, hour or day value. Disabled fields are not compared.
- R9: Writing control with bit 2 = 1 clears the alarm flag; writing bit 2 = 0 leaves it unchanged.
- R10: `irqOut` is high exactly when the alarm flag and the interrupt enable are both set.
- R11: A write to a time or day register loads the written value directly at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-second advance enable |
| addrIn | input | 8 | Register byte address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addrIn` |
| irqOut | output | 1 | Alarm interrupt |

## Verification
On every cycle the assertions check the following: no write reaches the registers while busy, a write parked during busy is applied once busy drops, seconds and the day count wrap to zero from their limits, the alarm flag rises only on a seconds rollover, a clearing write removes the flag, and the interrupt stays low without the flag. Several behaviours depend on chosen sequences and fixed values and are shown only by the bench scenarios. These are the BCD digit carries at each field boundary, midnight rollover into the day count and across its byte boundary, the per-field enables masking the alarm compare, the absence of a match away from second zero, and the cycle at which a parked write becomes visible.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h14;
  localparam logic [ADDR_W-1:0] A_SEC     = 8'h15;
  localparam logic [ADDR_W-1:0] A_MIN     = 8'h16;
  localparam logic [ADDR_W-1:0] A_HOUR    = 8'h17;
  localparam logic [ADDR_W-1:0] A_DAYLO   = 8'h18;
  localparam logic [ADDR_W-1:0] A_DAYHI   = 8'h19;
  localparam logic [ADDR_W-1:0] A_ALMMIN  = 8'h1A;
  localparam logic [ADDR_W-1:0] A_ALMHOUR = 8'h1B;
  localparam logic [ADDR_W-1:0] A_ALMDLO  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ALMDHI  = 8'h1D;

  // control register bit positions
  localparam int B_BUSY  = 7;
  localparam int B_DAYEN = 5;
  localparam int B_HREN  = 4;
  localparam int B_MINEN = 3;
  localparam int B_FLAG  = 2;
  localparam int B_IEN   = 1;
  localparam int B_RUN   = 0;

  typedef struct packed {
    logic              step;
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } calStrobe_t;

  // one BCD step with wrap at lim
  function automatic logic [7:0] bcdNext(input logic [7:0] v, input logic [7:0] lim);
    if (v == lim)           return 8'h00;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                    return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              calRun,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output calStrobe_t        stb,
  output logic              busy
);
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  always_comb begin
    busy       = calRun && tickEn;
    stb.step   = busy;
    stb.wrStb  = 1'b0;
    stb.wrAddr = addrIn;
    stb.wrData = wrData;
    if (!busy) begin
      if (pendValid) begin
        stb.wrStb  = 1'b1;
        stb.wrAddr = pendAddr;
        stb.wrData = pendData;
      end else if (wrEn) begin
        stb.wrStb = 1'b1;
      end
    end
  end

  // one-entry holding slot; the older parked write keeps priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (busy) begin
      if (!pendValid && wrEn) begin
        pendValid <= 1'b1;
        pendAddr  <= addrIn;
        pendData  <= wrData;
      end
    end else if (pendValid && wrEn) begin
      pendAddr <= addrIn;
      pendData <= wrData;
    end else begin
      pendValid <= 1'b0;
    end
  end

  p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> !busy);
  p_held_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !pendValid) |=> (busy || stb.wrStb));
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              calRun,
  output logic              almFlag,
  output logic              irqEn
);
  localparam int HI_W = DAY_W - 8;
  localparam int NFLD = 3;
  localparam logic [NFLD-1:0][7:0] LIMITS = {8'h23, 8'h59, 8'h59};
  localparam logic [NFLD-1:0][7:0] TADDR  = {A_HOUR, A_MIN, A_SEC};

  logic [NFLD-1:0][7:0] timeReg, nextVal;
  logic [NFLD:0]        carry;
  logic [DAY_W-1:0]     dayCnt, dayNext, almDay;
  logic [7:0]           almMin, almHour;
  logic                 dayAlmEn, hrAlmEn, minAlmEn;
  logic                 secRoll, dayInc, almHit;
  logic [NFLD-1:0]      fieldHit, fieldEn;
  logic [NFLD-1:0][DAY_W-1:0] almVal, curVal;

  always_comb begin
    carry[0] = stb.step;
    for (int i = 0; i < NFLD; i++) begin
      carry[i+1] = carry[i] && (timeReg[i] == LIMITS[i]);
      nextVal[i] = carry[i] ? bcdNext(timeReg[i], LIMITS[i]) : timeReg[i];
    end
    dayInc  = carry[NFLD];
    dayNext = dayInc ? dayCnt + 1'b1 : dayCnt;
    secRoll = carry[1];
  end

  // compare values: minute, hour, day
  assign almVal  = {almDay, DAY_W'(almHour), DAY_W'(almMin)};
  assign curVal  = {dayNext, DAY_W'(nextVal[2]), DAY_W'(nextVal[1])};
  assign fieldEn = {dayAlmEn, hrAlmEn, minAlmEn};

  generate
    for (genvar g = 0; g < NFLD; g++) begin : g_cmp
      assign fieldHit[g] = !fieldEn[g] || (almVal[g] == curVal[g]);
    end
  endgenerate

  assign almHit = secRoll && (|fieldEn) && (&fieldHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg <= '0;
    end else begin
      for (int i = 0; i < NFLD; i++) begin
        if (stb.wrStb && stb.wrAddr == TADDR[i]) timeReg[i] <= stb.wrData;
        else                                      timeReg[i] <= nextVal[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dayCnt <= '0;
    end else if (stb.wrStb && stb.wrAddr == A_DAYLO) begin
      dayCnt[7:0] <= stb.wrData;
    end else if (stb.wrStb && stb.wrAddr == A_DAYHI) begin
      dayCnt[DAY_W-1:8] <= stb.wrData[HI_W-1:0];
    end else begin
      dayCnt <= dayNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almMin  <= '0;
      almHour <= '0;
      almDay  <= '0;
    end else if (stb.wrStb) begin
      case (stb.wrAddr)
        A_ALMMIN:  almMin            <= stb.wrData;
        A_ALMHOUR: almHour           <= stb.wrData;
        A_ALMDLO:  almDay[7:0]       <= stb.wrData;
        A_ALMDHI:  almDay[DAY_W-1:8] <= stb.wrData[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {dayAlmEn, hrAlmEn, minAlmEn, irqEn, calRun} <= '0;
      almFlag <= 1'b0;
    end else begin
      if (stb.wrStb && stb.wrAddr == A_CTRL) begin
        dayAlmEn <= stb.wrData[B_DAYEN];
        hrAlmEn  <= stb.wrData[B_HREN];
        minAlmEn <= stb.wrData[B_MINEN];
        irqEn    <= stb.wrData[B_IEN];
        calRun   <= stb.wrData[B_RUN];
      end
      if (almHit)
        almFlag <= 1'b1;
      else if (stb.wrStb && stb.wrAddr == A_CTRL && stb.wrData[B_FLAG])
        almFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:    rdData = {busy, 1'b0, dayAlmEn, hrAlmEn, minAlmEn, almFlag, irqEn, calRun};
      A_SEC:     rdData = timeReg[0];
      A_MIN:     rdData = timeReg[1];
      A_HOUR:    rdData = timeReg[2];
      A_DAYLO:   rdData = dayCnt[7:0];
      A_DAYHI:   rdData = 8'(dayCnt[DAY_W-1:8]);
      A_ALMMIN:  rdData = almMin;
      A_ALMHOUR: rdData = almHour;
      A_ALMDLO:  rdData = almDay[7:0];
      A_ALMDHI:  rdData = 8'(almDay[DAY_W-1:8]);
      default:   rdData = '0;
    endcase
  end

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.wrStb && timeReg[0] == 8'h59) |=> (timeReg[0] == 8'h00));
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.step && !stb.wrStb) |=> $stable(timeReg[0]));
  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dayInc && dayCnt == {DAY_W{1'b1}}) |=> (dayCnt == '0));
  p_flag_rollover_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almFlag) |-> (timeReg[0] == 8'h00 && $past(stb.step)));
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.wrAddr == A_CTRL && stb.wrData[B_FLAG]) |=> !almFlag);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [7:0]  addrIn,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        irqOut
);
  calStrobe_t stb;
  logic busy, calRun, almFlag, irqEn;

  rtc_cal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .calRun(calRun),
    .wrEn(wrEn), .addrIn(addrIn), .wrData(wrData), .stb(stb), .busy(busy)
  );

  rtc_cal_datapath #(.DAY_W(DAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .rdAddr(addrIn),
    .rdData(rdData), .calRun(calRun), .almFlag(almFlag), .irqEn(irqEn)
  );

  assign irqOut = almFlag && irqEn;

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    !almFlag |-> !irqOut);
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] CTRL = 8'h14, SEC = 8'h15, MIN = 8'h16, HR = 8'h17,
    DLO = 8'h18, DHI = 8'h19, AMIN = 8'h1A, AHR = 8'h1B, ADLO = 8'h1C, ADHI = 8'h1D;

  logic clk = 0, rstN = 0, tickEn = 0, wrEn = 0, irqOut;
  logic [7:0] addrIn = 0, wrData = 0, rdData;
  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    bit         isIrq;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar u0 (.clk(clk), .rstN(rstN), .tickEn(tickEn), .addrIn(addrIn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  // monitor: compare the head of the scoreboard at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.isIrq ? {7'b0, irqOut} : rdData;
      nChecks++;
      if (act !== it.exp) begin
        nErrors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic expectNow(input logic [7:0] a, input logic [7:0] e, input bit irq, input string tag);
    addrIn = a;
    sb.push_back('{a, e, irq, tag});
    wait (sb.size() == 0);
  endtask

  task automatic chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expectNow(a, e, 1'b0, tag);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(posedge clk); #1;
    expectNow(8'h00, {7'b0, e}, 1'b1, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1; addrIn = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tickEn = 1;
    @(posedge clk); #1;
    tickEn = 0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk(CTRL, 8'h00, "R1 ctrl");
    chk(SEC, 8'h00, "R1 sec");
    chk(HR, 8'h00, "R1 hour");
    chk(DHI, 8'h00, "R1 dayhi");
    chk(AMIN, 8'h00, "R1 almmin");
    chkIrq(1'b0, "R1 irq");
    // R2 no advance while run bit clear
    tick();
    chk(SEC, 8'h00, "R2 halted");
    wr(CTRL, 8'h01);
    tick(); tick(); tick();
    chk(SEC, 8'h03, "R2 count");
    wr(SEC, 8'h09); tick();
    chk(SEC, 8'h10, "R2 digit carry");
    // R2/R3 seconds into minutes
    wr(SEC, 8'h59); wr(MIN, 8'h07); tick();
    chk(SEC, 8'h00, "R2 sec wrap");
    chk(MIN, 8'h08, "R2 carry to min");
    wr(SEC, 8'h59); wr(MIN, 8'h59); wr(HR, 8'h05); tick();
    chk(MIN, 8'h00, "R3 min wrap");
    chk(HR, 8'h06, "R3 carry to hour");
    wr(SEC, 8'h59); wr(MIN, 8'h59); wr(HR, 8'h09); tick();
    chk(HR, 8'h10, "R3 hour digit");
    // R4 midnight
    wr(DLO, 8'hFF); wr(DHI, 8'h00);
    wr(SEC, 8'h59); wr(MIN, 8'h59); wr(HR, 8'h23); tick();
    chk(HR, 8'h00, "R4 hour wrap");
    chk(DLO, 8'h00, "R4 daylo byte carry");
    chk(DHI, 8'h01, "R4 dayhi byte carry");
    wr(DHI, 8'hFF);
    chk(DHI, 8'h7F, "R4 dayhi bit7");
    wr(DLO, 8'hFF);
    wr(SEC, 8'h59); wr(MIN, 8'h59); wr(HR, 8'h23); tick();
    chk(DLO, 8'h00, "R4 day wrap lo");
    chk(DHI, 8'h00, "R4 day wrap hi");
    // R11 direct loads
    wr(HR, 8'h17);
    chk(HR, 8'h17, "R11 hour load");
    // R5 alarm registers
    wr(AMIN, 8'h31); wr(AHR, 8'h22); wr(ADLO, 8'h24); wr(ADHI, 8'hC1);
    chk(AMIN, 8'h31, "R5 almmin");
    chk(AHR, 8'h22, "R5 almhour");
    chk(ADLO, 8'h24, "R5 almdlo");
    chk(ADHI, 8'h41, "R5 almdhi");
    chk(8'h1E, 8'h00, "R5 unmapped");
    // R6 control layout
    wr(CTRL, 8'hFF);
    chk(CTRL, 8'h3B, "R6 ctrl bits");
    wr(CTRL, 8'h01);
    // R7 busy and held write
    wr(SEC, 8'h10); wr(MIN, 8'h05);
    @(posedge clk); #1;
    tickEn = 1;
    expectNow(CTRL, 8'h81, 1'b0, "R7 busy");
    @(posedge clk); #1;
    wrEn = 1; addrIn = MIN; wrData = 8'h33;
    @(posedge clk); #1;
    tickEn = 0; wrEn = 0;
    expectNow(MIN, 8'h05, 1'b0, "R7 held not yet applied");
    chk(MIN, 8'h33, "R7 held applied");
    chk(SEC, 8'h12, "R7 ticks counted");
    // R8 minute alarm, interrupt disabled
    wr(CTRL, 8'h09);
    wr(SEC, 8'h59); wr(MIN, 8'h30); wr(HR, 8'h05); tick();
    chk(CTRL, 8'h0D, "R8 minute match");
    chkIrq(1'b0, "R10 irq masked");
    wr(CTRL, 8'h0B);
    chk(CTRL, 8'h0F, "R9 write0 keeps flag");
    chkIrq(1'b1, "R10 irq asserted");
    wr(CTRL, 8'h0F);
    chk(CTRL, 8'h0B, "R9 w1c");
    chkIrq(1'b0, "R10 irq cleared");
    // R8 enabled hour mismatches
    wr(CTRL, 8'h19);
    wr(SEC, 8'h59); wr(MIN, 8'h30); wr(HR, 8'h05); tick();
    chk(CTRL, 8'h19, "R8 hour mismatch");
    // R8 no compare away from second zero
    wr(CTRL, 8'h09); wr(SEC, 8'h10); wr(MIN, 8'h31); tick();
    chk(CTRL, 8'h09, "R8 not at sec zero");
    // R8 day alarm only
    wr(CTRL, 8'h21); wr(ADHI, 8'h01);
    wr(DLO, 8'h24); wr(DHI, 8'h01);
    wr(SEC, 8'h59); wr(MIN, 8'h10); wr(HR, 8'h03); tick();
    chk(CTRL, 8'h25, "R8 day match");
    finished = 1;
    summary();
    $finish;
  end
endmodule